// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM. The host hands over one word at a time on a valid/ready port: a write with address and data, or a read with an address. The controller then drives the active-low chip-select, write-enable and output-enable strobes, a 15-bit address and an 8-bit data bus split into out, out-enable and in signals. A read returns its byte with a one-cycle done pulse.

Every timing minimum of the RAM is converted at elaboration into a whole number of clock cycles. The conversion uses ceiling division of the grade's nanosecond limit by the clock period parameter, with at least one cycle per nonzero limit. The speed grade parameter (55, 70 or 85) selects the limits. After every read the controller waits out the time the RAM may keep driving the data lines before the host side may drive them again. Write data stays driven for at least one cycle after write-enable rises.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, chip-select, write-enable and output-enable are high, the data drivers are off, the host port is ready and the done output is low.
- R2: Each phase length in cycles equals ceil(limit_ns / CLK_NS), at least 1. The limits in ns for grades 55/70/85 are: write pulse 40/50/55, write cycle 55/70/85, data-valid-before-end-of-write 25/35/40, address access and read cycle 55/70/85, output-enable access 30/35/45, output float after deselect 20/30/30.
- R3: A write lowers chip-select and write-enable on the same clock edge, keeps output-enable high, and holds both strobes low for the write pulse count, which is the larger of the pulse and data-valid counts.
- R4: A write occupies the controller for the write cycle count, and at least pulse count + 1 cycles. The data drivers are on for the whole pulse and for every recovery cycle after write-enable rises.
- R5: A read lowers chip-select and output-enable with write-enable high for the larger of the access and output-enable counts. The data input is sampled on the edge that ends this phase and appears on rd_data_o while rd_done_o is high for exactly one cycle, in the cycle after that edge.
- R6: After a read, the strobes stay high for the float count before the controller returns to idle. The data drivers never turn on while the RAM may still be driving the bus.
- R7: req_ready_o is high only while idle. Whenever it is high, all strobes are high and the drivers are off. A request is taken only on a cycle with req_valid_i and req_ready_o both high.
- R8: Address and write data are captured at request acceptance and held stable on the RAM pins for the whole operation. A read of an address returns the byte most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW (15) | Word address |
| req_wdata_i | input | DW (8) | Write data |
| rd_data_o | output | DW (8) | Read data, valid with rd_done_o |
| rd_done_o | output | 1 | One-cycle read completion pulse |
| sram_cs_n_o | output | 1 | RAM chip select, active low |
| sram_we_n_o | output | 1 | RAM write enable, active low |
| sram_oe_n_o | output | 1 | RAM output enable, active low |
| sram_addr_o | output | AW (15) | RAM address |
| sram_data_o | output | DW (8) | Data toward the RAM |
| sram_data_oe_o | output | 1 | Drive enable for sram_data_o |
| sram_data_i | input | DW (8) | Data from the RAM pins |

## Verification
The hardest case to reach from the ports is a sample taken too early, or a driver switched on while the RAM still floats its outputs. A correct-looking byte can hide both. The bench RAM model therefore measures elapsed nanoseconds from the strobe edges. It returns a poison byte until the access time has passed and keeps driving poison for the float time after a read ends. Any shortened phase then shows up as wrong read data or a counted bus clash. Back-to-back writes and reads, with each read following its write directly, keep the turnaround windows as short as the host port allows.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_REC, ST_RD, ST_TA
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned wp_ns(input int unsigned g);
    return (g == 55) ? 40 : (g == 70) ? 50 : 55;
  endfunction

  function automatic int unsigned wc_ns(input int unsigned g);
    return (g == 55) ? 55 : (g == 70) ? 70 : 85;
  endfunction

  function automatic int unsigned dw_ns(input int unsigned g);
    return (g == 55) ? 25 : (g == 70) ? 35 : 40;
  endfunction

  function automatic int unsigned acc_ns(input int unsigned g);
    return (g == 55) ? 55 : (g == 70) ? 70 : 85;
  endfunction

  function automatic int unsigned oe_ns(input int unsigned g);
    return (g == 55) ? 30 : (g == 70) ? 35 : 45;
  endfunction

  function automatic int unsigned hz_ns(input int unsigned g);
    return (g == 55) ? 20 : 30;
  endfunction

endpackage

// File: rtl/sram_cycle_cnt.sv
module sram_cycle_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW      = 4,
  parameter int unsigned WP_CYC  = 1,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned RD_CYC  = 1,
  parameter int unsigned HZ_CYC  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic          cnt_zero_i,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_val_o,
  output logic          ready_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          cs_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic          drv_en_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        cnt_load_o = 1'b1;
        if (req_we_i) begin
          state_d   = ST_WR;
          cnt_val_o = CW'(WP_CYC - 1);
        end else begin
          state_d   = ST_RD;
          cnt_val_o = CW'(RD_CYC - 1);
        end
      end
      ST_WR: if (cnt_zero_i) begin
        state_d    = ST_REC;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(REC_CYC - 1);
      end
      ST_REC: if (cnt_zero_i) state_d = ST_IDLE;
      ST_RD: if (cnt_zero_i) begin
        state_d    = ST_TA;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(HZ_CYC - 1);
      end
      ST_TA: if (cnt_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o && req_valid_i;
  assign capture_o = (state_q == ST_RD) && cnt_zero_i;

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      drv_en_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      cs_n_o   <= !(state_d == ST_WR || state_d == ST_RD);
      we_n_o   <= !(state_d == ST_WR);
      oe_n_o   <= !(state_d == ST_RD);
      drv_en_o <= (state_d == ST_WR || state_d == ST_REC);
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned GRADE  = 55,
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned AW     = 15,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_done_o,
  output logic          sram_cs_n_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_data_o,
  output logic          sram_data_oe_o,
  input  logic [DW-1:0] sram_data_i
);
  localparam int unsigned WP_CYC  = max2(ns_to_cyc(wp_ns(GRADE), CLK_NS),
                                         ns_to_cyc(dw_ns(GRADE), CLK_NS));
  localparam int unsigned WC_CYC  = max2(ns_to_cyc(wc_ns(GRADE), CLK_NS), WP_CYC + 1);
  localparam int unsigned REC_CYC = WC_CYC - WP_CYC;
  localparam int unsigned RD_CYC  = max2(ns_to_cyc(acc_ns(GRADE), CLK_NS),
                                         ns_to_cyc(oe_ns(GRADE), CLK_NS));
  localparam int unsigned HZ_CYC  = ns_to_cyc(hz_ns(GRADE), CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(WC_CYC, RD_CYC), HZ_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC + 2);

  logic          cnt_load, cnt_zero, accept, capture;
  logic [CW-1:0] cnt_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q;

  sram_cycle_cnt #(.CW(CW)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  sram_seq_fsm #(
    .CW(CW), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .cnt_zero_i  (cnt_zero),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .cs_n_o      (sram_cs_n_o),
    .we_n_o      (sram_we_n_o),
    .oe_n_o      (sram_oe_n_o),
    .drv_en_o    (sram_data_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= capture;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_q <= sram_data_i;
    end
  end

  assign sram_addr_o = addr_q;
  assign sram_data_o = wdata_q;
  assign rd_data_o   = rdata_q;
  assign rd_done_o   = done_q;

  // checker state: write-low run length and cycles since output-enable rose
  logic [CW-1:0] wp_run_q, hz_gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_run_q <= '0;
      hz_gap_q <= CW'(HZ_CYC);
    end else begin
      wp_run_q <= sram_we_n_o ? '0 : wp_run_q + 1'b1;
      if (!sram_oe_n_o)                hz_gap_q <= '0;
      else if (hz_gap_q < CW'(HZ_CYC)) hz_gap_q <= hz_gap_q + 1'b1;
    end
  end

  // R3
  wp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> wp_run_q >= CW'(WP_CYC));
  // R3
  we_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_n_o) |-> $fell(sram_cs_n_o) && sram_oe_n_o);
  // R4
  hold_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> sram_data_oe_o);
  // R5
  rd_we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> sram_we_n_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
  // R6
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_data_oe_o) |-> hz_gap_q >= CW'(HZ_CYC));
  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> sram_cs_n_o && sram_we_n_o && sram_oe_n_o && !sram_data_oe_o);
  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs_n_o && $past(!sram_cs_n_o) |-> $stable(sram_addr_o));
endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;
  localparam int GR   = 70;
  localparam int CK   = 8;
  localparam int T_WP = 50;
  localparam int T_WC = 70;
  localparam int T_AA = 70;
  localparam int T_HZ = 30;
  localparam int E_WP = (T_WP + CK - 1) / CK;
  localparam int E_WC = ((T_WC + CK - 1) / CK > E_WP + 1) ? (T_WC + CK - 1) / CK : E_WP + 1;
  localparam int E_RD = (T_AA + CK - 1) / CK;
  localparam int E_HZ = (T_HZ + CK - 1) / CK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_done, cs_n, we_n, oe_n, data_oe;
  logic [7:0]  rd_data, data_o;
  logic [14:0] ram_addr;
  logic [7:0]  bus;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sram_strobe_ctrl #(.GRADE(GR), .CLK_NS(CK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .rd_done_o(rd_done),
    .sram_cs_n_o(cs_n), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n),
    .sram_addr_o(ram_addr), .sram_data_o(data_o), .sram_data_oe_o(data_oe),
    .sram_data_i(bus)
  );

  // behavioural RAM: timing measured in ns from strobe edges
  logic [7:0] mem [0:255];
  int  rd_cyc = 0, hz_left = 0, wcnt = 0;
  logic [7:0] wlatch = '0;
  logic [7:0] waddr = '0;
  logic p_cs = 1'b1, p_we = 1'b1;
  int  clash = 0, short_wp = 0, order_bad = 0, drv_gap = 0, busy_noisy = 0;
  logic read_act, ram_drv;
  logic [7:0] ram_val;

  assign read_act = !cs_n && we_n && !oe_n;
  assign ram_drv  = read_act || (hz_left != 0);
  assign ram_val  = (read_act && rd_cyc * CK >= T_AA) ? mem[ram_addr[7:0]] : 8'hEE;
  assign bus      = ram_drv ? ram_val : (data_oe ? data_o : 8'h00);

  always @(negedge clk) if (rst_n) begin
    if (read_act) begin rd_cyc <= rd_cyc + 1; hz_left <= E_HZ + 1; end
    else begin rd_cyc <= 0; if (hz_left > 0) hz_left <= hz_left - 1; end
    if (!cs_n && !we_n) begin
      wcnt   <= wcnt + 1;
      wlatch <= bus;
      waddr  <= ram_addr[7:0];
      if (!data_oe || !oe_n) drv_gap <= drv_gap + 1;
      if (!p_cs && p_we) order_bad <= order_bad + 1;
    end else if (wcnt > 0) begin
      mem[waddr] <= wlatch;
      if (wcnt * CK < T_WP) short_wp <= short_wp + 1;
      if (!data_oe) drv_gap <= drv_gap + 1;
      wcnt <= 0;
    end
    if (data_oe && ram_drv) clash <= clash + 1;
    if (req_ready && (!cs_n || !we_n || !oe_n || data_oe)) busy_noisy <= busy_noisy + 1;
    p_cs <= cs_n;
    p_we <= we_n;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int n;
    n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin n++; @(negedge clk); end
    chk(n == E_WC, "R4", "write busy cycles", n, E_WC);
  endtask

  task automatic do_read(input logic [14:0] a, input logic [7:0] exp_d);
    int n, done_at, dn;
    logic [7:0] got;
    n = 0; done_at = 0; dn = 0; got = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      n++;
      if (rd_done) begin dn++; if (done_at == 0) done_at = n; got = rd_data; end
      @(negedge clk);
    end
    chk(got == exp_d, "R8", "read data", int'(got), int'(exp_d));
    chk(done_at == E_RD + 1, "R5", "done latency", done_at, E_RD + 1);
    chk(dn == 1, "R5", "done pulse width", dn, 1);
    chk(n == E_RD + E_HZ, "R6", "read busy cycles", n, E_RD + E_HZ);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && we_n && oe_n, "R1", "strobes high", {cs_n, we_n, oe_n}, 7);
    chk(!data_oe, "R1", "drivers off", data_oe, 0);
    chk(req_ready, "R1", "ready", req_ready, 1);
    chk(!rd_done, "R1", "done low", rd_done, 0);
    rst_n = 1'b1;
    // R2 sweep: full write pass, then read-back
    for (int i = 0; i < 32; i++)
      do_write(15'(i * 1024 + i), 8'((i * 29 + 7) & 8'hFF));
    for (int i = 31; i >= 0; i--)
      do_read(15'(i * 1024 + i), 8'((i * 29 + 7) & 8'hFF));
    // read directly after write, tightest turnaround
    for (int i = 0; i < 24; i++) begin
      do_write(15'((i * 4099 + 40) & 15'h7FFF), 8'((i * 113 + 91) & 8'hFF));
      do_read(15'((i * 4099 + 40) & 15'h7FFF), 8'((i * 113 + 91) & 8'hFF));
    end
    repeat (4) @(negedge clk);
    chk(clash == 0, "R6", "bus clashes", clash, 0);
    chk(short_wp == 0, "R3", "short write pulses", short_wp, 0);
    chk(order_bad == 0, "R3", "select before write-enable", order_bad, 0);
    chk(drv_gap == 0, "R4", "write cycles without drive", drv_gap, 0);
    chk(busy_noisy == 0, "R7", "strobes active while ready", busy_noisy, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule